// File: doc/BRIEF.md
# Spectral Pattern Sequence Trigger

This block turns a stream of per-bin pattern scores into a single-cycle trigger. A 24-deep window holds the most recent 10-bit ADC samples, advancing once per sample strobe. A bank of transform engines, outside this block, scores every time bin and reports one metric per bin with a fixed latency of 8 strobes behind the window. The block keeps the last four scores. It fires when the oldest of the four lies in the rising-edge band and the three newer ones all lie in the decay band, which is the signature of a sharp jump followed by exponential attenuation.

A multiplexer chosen per history stage decides which threshold pair each stored score is compared against. The oldest stage uses the edge pair and every newer stage uses the decay pair. An amplitude comparator across the whole sample window can veto a firing. The block takes no scores until 32 strobes have filled the window and the engine pipeline. After each firing it empties the history, so a new event needs four fresh bins.

Top module: `spectral_seq_trigger`

## Requirements
- R1: While `rst_n` is low, `trig` is 0. Reset empties the score history and restarts the arming count.
- R2: No score is accepted into the history until 32 strobes (`smp_en` high at a rising edge) have occurred since reset. The earliest firing follows the 36th strobe.
- R3: On an accepted strobe, the block fires if all of the following hold: the history holds four scores counting the new one, the oldest of the four is in [`jump_lo`, `jump_hi`], the three newer ones are in [`tail_lo`, `tail_hi`], and no veto is active. `trig` is then high for the clock cycle after that strobe edge.
- R4: Order matters. Three decay-band scores followed by an edge-band score do not fire.
- R5: If any of the four scores falls outside its band, the block does not fire.
- R6: A veto is active when any of the 24 samples in the window, counting the sample arriving with the current strobe, is greater than or equal to `veto_thr`. A firing is suppressed while a veto is active.
- R7: `trig` is never high for two cycles in a row. A firing empties the history, so the next firing needs four new accepted scores.
- R8: While `smp_en` is low, the window, history and arming count stay unchanged, and `smp_data` and `eng_metric` have no effect.
- R9: Both band limits are inclusive. A score equal to a limit matches, and a score one step outside does not.
- R10: A sample leaves the veto window 24 strobes after it arrived. It vetoes the strobe that brings it in and the next 23 strobes, and no later ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample strobe. Advances the window and offers a score |
| smp_data | input | 10 | ADC sample entering the window |
| eng_metric | input | 8 | Transform engine score for the current bin |
| jump_lo | input | 8 | Lower limit of the edge band |
| jump_hi | input | 8 | Upper limit of the edge band |
| tail_lo | input | 8 | Lower limit of the decay band |
| tail_hi | input | 8 | Upper limit of the decay band |
| veto_thr | input | 10 | Amplitude veto level |
| trig | output | 1 | Single-cycle final trigger |

## Verification
The assertions assume that `smp_en` is 0 during reset. They also assume that the band and veto thresholds change only while no strobe is in flight. Otherwise a firing could not be tied to the values present at its strobe. The bench drives every input at the falling edge, and it never changes a threshold in the same cycle as a strobe. It also leaves at least one idle cycle between strobes, so the one-cycle pulse can be seen falling before the next bin arrives. Scores come from synthetic decaying pulses mixed with flat noise bins. Some runs use an edge band that overlaps the decay band on purpose, to show that the history is emptied after a firing.

// File: rtl/spt_pkg.sv
package spt_pkg;

  localparam int SAMPLE_W_DEF   = 10;
  localparam int METRIC_W_DEF   = 8;
  localparam int WIN_DEPTH_DEF  = 24;
  localparam int ENG_LAT_DEF    = 8;
  localparam int HIST_DEPTH_DEF = 4;

  // Which threshold pair a history stage is compared against.
  typedef enum logic {
    STAGE_EDGE = 1'b0,
    STAGE_TAIL = 1'b1
  } stage_kind_e;

  // Stage 0 is the newest score; the oldest stage must be the rising edge.
  function automatic stage_kind_e stage_kind(input int stage, input int depth);
    return (stage == depth - 1) ? STAGE_EDGE : STAGE_TAIL;
  endfunction

endpackage

// File: rtl/spt_sample_window.sv
module spt_sample_window #(
  parameter int DEPTH = 24,
  parameter int SW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic [SW-1:0] din,
  input  logic [SW-1:0] veto_thr,
  output logic          veto_o
);

  logic [DEPTH-1:0][SW-1:0] win_q;
  logic [DEPTH-1:0][SW-1:0] win_d;
  logic [DEPTH-1:0]         over;

  // Next-state: node 0 takes the new sample, all others move one node on.
  always_comb begin
    win_d = win_q;
    if (shift_en) begin
      win_d[0] = din;
      for (int i = 1; i < DEPTH; i++) begin
        win_d[i] = win_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (shift_en) begin
      win_q <= win_d;
    end
  end

  // One comparator per node of the window as it stands after this strobe.
  for (genvar n = 0; n < DEPTH; n++) begin : g_cmp
    assign over[n] = (win_d[n] >= veto_thr);
  end

  assign veto_o = |over;

endmodule

// File: rtl/spt_arm_counter.sv
module spt_arm_counter #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic armed_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = tick_i && (cnt_q != LIMIT_V);

  always_comb begin
    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign armed_o = (cnt_q == LIMIT_V);

endmodule

// File: rtl/spt_bin_history.sv
module spt_bin_history
  import spt_pkg::*;
#(
  parameter int HD = 4,
  parameter int MW = 8,
  localparam int CW = $clog2(HD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          clear_i,
  input  logic [MW-1:0] metric_i,
  input  logic [MW-1:0] jump_lo_i,
  input  logic [MW-1:0] jump_hi_i,
  input  logic [MW-1:0] tail_lo_i,
  input  logic [MW-1:0] tail_hi_i,
  output logic          match_o,
  output logic [CW-1:0] count_o
);

  localparam logic [CW-1:0] FULL_V = CW'(HD);
  localparam logic [CW-1:0] NEAR_V = CW'(HD - 1);

  logic [HD-1:0][MW-1:0] hist_q;
  logic [HD-1:0][MW-1:0] hist_d;
  logic [HD-1:0][MW-1:0] cand;
  logic [CW-1:0]         cnt_q;
  logic [CW-1:0]         cnt_d;
  logic [HD-1:0]         stage_ok;

  // Candidate history as it would look once this score is taken in.
  assign cand[0] = metric_i;
  for (genvar s = 1; s < HD; s++) begin : g_cand
    assign cand[s] = hist_q[s-1];
  end

  // Per-stage threshold mux and window compare.
  for (genvar s = 0; s < HD; s++) begin : g_stage
    localparam stage_kind_e KIND = stage_kind(s, HD);
    logic [MW-1:0] lo_sel;
    logic [MW-1:0] hi_sel;
    assign lo_sel = (KIND == STAGE_EDGE) ? jump_lo_i : tail_lo_i;
    assign hi_sel = (KIND == STAGE_EDGE) ? jump_hi_i : tail_hi_i;
    assign stage_ok[s] = (cand[s] >= lo_sel) && (cand[s] <= hi_sel);
  end

  assign match_o = (cnt_q >= NEAR_V) && (&stage_ok);
  assign count_o = cnt_q;

  always_comb begin
    hist_d = hist_q;
    cnt_d  = cnt_q;
    if (push_i) begin
      hist_d = cand;
      if (clear_i) begin
        cnt_d = '0;
      end else if (cnt_q != FULL_V) begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (push_i) begin
      hist_q <= hist_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/spectral_seq_trigger.sv
module spectral_seq_trigger
  import spt_pkg::*;
#(
  parameter int SAMPLE_W   = SAMPLE_W_DEF,
  parameter int METRIC_W   = METRIC_W_DEF,
  parameter int WIN_DEPTH  = WIN_DEPTH_DEF,
  parameter int ENG_LAT    = ENG_LAT_DEF,
  parameter int HIST_DEPTH = HIST_DEPTH_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_en,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [METRIC_W-1:0] eng_metric,
  input  logic [METRIC_W-1:0] jump_lo,
  input  logic [METRIC_W-1:0] jump_hi,
  input  logic [METRIC_W-1:0] tail_lo,
  input  logic [METRIC_W-1:0] tail_hi,
  input  logic [SAMPLE_W-1:0] veto_thr,
  output logic                trig
);

  localparam int ARM_COUNT = WIN_DEPTH + ENG_LAT;
  localparam int HCW       = $clog2(HIST_DEPTH + 1);

  logic           armed;
  logic           veto_hit;
  logic           push;
  logic           seq_match;
  logic           fire;
  logic [HCW-1:0] hist_cnt;
  logic           trig_q;
  logic           trig_d;

  spt_sample_window #(
    .DEPTH (WIN_DEPTH),
    .SW    (SAMPLE_W)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (smp_en),
    .din      (smp_data),
    .veto_thr (veto_thr),
    .veto_o   (veto_hit)
  );

  spt_arm_counter #(
    .LIMIT (ARM_COUNT)
  ) u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (smp_en),
    .armed_o (armed)
  );

  assign push = smp_en && armed;
  assign fire = push && seq_match && !veto_hit;

  spt_bin_history #(
    .HD (HIST_DEPTH),
    .MW (METRIC_W)
  ) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push),
    .clear_i   (fire),
    .metric_i  (eng_metric),
    .jump_lo_i (jump_lo),
    .jump_hi_i (jump_hi),
    .tail_lo_i (tail_lo),
    .tail_hi_i (tail_hi),
    .match_o   (seq_match),
    .count_o   (hist_cnt)
  );

  always_comb begin
    trig_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_d;
    end
  end

  assign trig = trig_q;

endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
  parameter int HD  = 4,
  parameter int HCW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           smp_en,
  input logic           trig,
  input logic           armed,
  input logic           veto_hit,
  input logic [HCW-1:0] hist_cnt
);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  assert_history_emptied_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (hist_cnt == '0));

  assert_strobe_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(smp_en));

  assert_armed_before_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(armed));

  assert_veto_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> !$past(veto_hit));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(hist_cnt));

  assert_history_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hist_cnt <= HCW'(HD));

endmodule

bind spectral_seq_trigger spt_checker #(
  .HD  (HIST_DEPTH),
  .HCW (HCW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_en   (smp_en),
  .trig     (trig),
  .armed    (armed),
  .veto_hit (veto_hit),
  .hist_cnt (hist_cnt)
);

// File: tb/spectral_seq_trigger_tb.sv
module spectral_seq_trigger_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDEPTH     = 24;
  localparam int ARM        = 32;

  logic       clk;
  logic       rst_n;
  logic       smp_en;
  logic [9:0] smp_data;
  logic [7:0] eng_metric;
  logic [7:0] jump_lo, jump_hi, tail_lo, tail_hi;
  logic [9:0] veto_thr;
  logic       trig;

  int n_checks = 0;
  int n_fails  = 0;

  // Reference model state
  int m_win [WDEPTH];
  int m_fill;
  int m_cnt;
  int m_hist [4];

  spectral_seq_trigger dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (smp_en),
    .smp_data   (smp_data),
    .eng_metric (eng_metric),
    .jump_lo    (jump_lo),
    .jump_hi    (jump_hi),
    .tail_lo    (tail_lo),
    .tail_hi    (tail_hi),
    .veto_thr   (veto_thr),
    .trig       (trig)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    summary();
  end

  task automatic check(input string tag, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: trig actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic bit in_band(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  task automatic model_reset();
    foreach (m_win[i]) m_win[i] = 0;
    foreach (m_hist[i]) m_hist[i] = 0;
    m_fill = 0;
    m_cnt  = 0;
  endtask

  task automatic model_step(input int d, input int m, output bit exp);
    bit veto;
    bit take;
    for (int i = WDEPTH - 1; i > 0; i--) m_win[i] = m_win[i-1];
    m_win[0] = d;
    veto = 1'b0;
    foreach (m_win[i]) if (m_win[i] >= int'(veto_thr)) veto = 1'b1;
    take = (m_fill == ARM);
    if (m_fill < ARM) m_fill++;
    exp = 1'b0;
    if (take) begin
      for (int i = 3; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = m;
      if (m_cnt < 4) m_cnt++;
      if (m_cnt == 4 && !veto
          && in_band(m_hist[3], jump_lo, jump_hi)
          && in_band(m_hist[2], tail_lo, tail_hi)
          && in_band(m_hist[1], tail_lo, tail_hi)
          && in_band(m_hist[0], tail_lo, tail_hi)) begin
        exp = 1'b1;
        m_cnt = 0;
      end
    end
  endtask

  // One strobe; result checked one cycle after the strobe edge.
  task automatic strobe(input string tag, input int d, input int m);
    bit exp;
    @(negedge clk);
    smp_en = 1'b1;
    smp_data = 10'(d);
    eng_metric = 8'(m);
    model_step(d, m, exp);
    @(negedge clk);
    smp_en = 1'b0;
    check(tag, trig, exp);
  endtask

  task automatic noise(input string tag, input int n);
    for (int i = 0; i < n; i++) strobe(tag, 10 + (i % 3), 0);
  endtask

  // Decaying pulse: edge score then three tail scores.
  task automatic pulse(input string tag, input int j, input int t0, input int t1, input int t2);
    strobe(tag, 500, j);
    strobe(tag, 300, t0);
    strobe(tag, 180, t1);
    strobe(tag, 110, t2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    smp_en = 1'b0;
    model_reset();
    @(negedge clk);
    check("R1 reset", trig, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", trig, 1'b0);
  endtask

  task automatic t_arming();
    for (int i = 0; i < 8; i++) pulse("R2 arming", 220, 80, 60, 50);
    pulse("R3 first pulse", 220, 80, 60, 50);
  endtask

  task automatic t_basic();
    noise("R3 noise", 5);
    pulse("R3 pulse a", 230, 100, 70, 45);
    noise("R3 noise", 2);
    pulse("R3 pulse b", 200, 120, 40, 90);
  endtask

  task automatic t_order();
    strobe("R4 reversed", 300, 80);
    strobe("R4 reversed", 200, 70);
    strobe("R4 reversed", 120, 60);
    strobe("R4 reversed", 500, 230);
    noise("R4 flush", 4);
  endtask

  task automatic t_broken();
    strobe("R5 broken", 500, 230);
    strobe("R5 broken", 300, 80);
    strobe("R5 broken", 180, 0);
    strobe("R5 broken", 110, 60);
    strobe("R5 broken", 500, 230);
    strobe("R5 broken", 300, 150);
    strobe("R5 broken", 180, 70);
    strobe("R5 broken", 110, 60);
    noise("R5 flush", 4);
  endtask

  task automatic t_bounds();
    pulse("R9 edges", 255, 40, 120, 40);
    pulse("R9 below jump", 199, 60, 60, 60);
    noise("R9 flush", 4);
    pulse("R9 above tail", 210, 60, 121, 60);
    noise("R9 flush", 4);
    pulse("R9 below tail", 210, 39, 60, 60);
    noise("R9 flush", 4);
  endtask

  task automatic t_veto();
    strobe("R6 veto", 950, 0);
    noise("R6 veto", 19);
    pulse("R6 vetoed pulse", 230, 80, 60, 50);
    noise("R10 flush", 30);
    strobe("R10 expiry", 900, 0);
    noise("R10 expiry", 20);
    pulse("R10 expired pulse", 230, 80, 60, 50);
    noise("R10 flush", 24);
    strobe("R6 level", 899, 0);
    noise("R6 level", 2);
    pulse("R6 below level", 230, 80, 60, 50);
  endtask

  task automatic t_clear();
    @(negedge clk);
    tail_hi = 8'd255;
    for (int i = 0; i < 8; i++) strobe("R7 cleared", 200, 230);
    @(negedge clk);
    check("R7 low after", trig, 1'b0);
    tail_hi = 8'd120;
    noise("R7 flush", 4);
  endtask

  task automatic t_idle();
    @(negedge clk);
    smp_data = 10'd1023;
    eng_metric = 8'd230;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R8 idle", trig, 1'b0);
    end
    pulse("R8 after idle", 230, 80, 60, 50);
  endtask

  task automatic t_mid_reset();
    strobe("R1 partial", 500, 230);
    strobe("R1 partial", 300, 80);
    strobe("R1 partial", 180, 60);
    do_reset();
    for (int i = 0; i < ARM; i++) strobe("R1 rearm", 10, 0);
    strobe("R1 stale history", 110, 60);
    pulse("R1 fresh pulse", 230, 80, 60, 50);
  endtask

  initial begin
    rst_n = 1'b0;
    smp_en = 1'b0;
    smp_data = '0;
    eng_metric = '0;
    jump_lo = 8'd200;
    jump_hi = 8'd255;
    tail_lo = 8'd40;
    tail_hi = 8'd120;
    veto_thr = 10'd900;
    model_reset();
    do_reset();
    t_arming();
    t_basic();
    t_order();
    t_broken();
    t_bounds();
    t_veto();
    t_clear();
    t_idle();
    t_mid_reset();
    summary();
  end

endmodule